// File: doc/BRIEF.md
# Single-Wire Pulse-Width Frame Monitor

This block passively watches a single-wire serial line whose idle level is high. Each transmitted symbol is a low pulse, and only the length of that low pulse carries meaning. The monitor passes the line through a two-flop synchronizer and counts, in system clock cycles, how long each low lasts. When the line rises again it sorts the pulse into one of four kinds: a break, a logic 0, a logic 1, or an invalid pulse that belongs to no window. All duration windows are given in microseconds and converted to clock cycles at elaboration from the clock frequency parameter `CLK_HZ`.

Decoded bits feed a three-state frame parser. The states are ADDR (collecting the address), DIR (expecting the direction bit) and DATA (collecting the data byte). The parser moves ADDR to DIR after the seventh address bit, DIR to DATA on the direction bit, and DATA back to ADDR after the eighth data bit. A break takes every state back to ADDR. An invalid pulse causes no transition. Each field is reported with its own one-cycle strobe. The captured address and direction stay on their outputs until the next frame overwrites them, so a consumer can read all three fields when the data strobe fires.

Top module: `pw_frame_mon`

## Requirements
- R1: The low duration is the number of clock cycles the synchronized line stays low, counted from the falling edge to the next rising edge. A pulse is classified only when the line rises.
- R2: A low longer than 190 us makes `brk_o` pulse for one cycle. It returns the parser to ADDR and discards any partially received frame.
- R3: A low of 86 us to 145 us inclusive decodes as bit value 0.
- R4: A low of 17 us to 50 us inclusive decodes as bit value 1.
- R5: A low outside every window produces no bit and no break, and leaves the parser state and bit position unchanged. Examples are 16, 51, 85, 146 and 190 us.
- R6: The first 7 bits of a frame form the address, least significant bit first. `addr_valid_o` pulses for one cycle while `addr_o` carries the new address.
- R7: The bit after the address is the direction: 1 means write and 0 means read. It appears on `dir_o` together with a one-cycle `dir_valid_o`.
- R8: The next 8 bits form the data byte, least significant bit first. It appears on `data_o` with a one-cycle `data_valid_o`, after which the parser is back in ADDR.
- R9: `addr_o` and `dir_o` change only in the cycle of their own strobe, so they still hold the current frame's values when `data_valid_o` fires.
- R10: The cycle thresholds are CLK_HZ*us/1e6. The pulse counter saturates, so a low of any length beyond the break limit still reports a break.
- R11: A synchronous active-high reset clears the outputs and strobes and puts the parser in ADDR at bit position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Asynchronous serial line, idle high |
| addr_o | output | 7 | Last captured address |
| addr_valid_o | output | 1 | One-cycle strobe for a new address |
| dir_o | output | 1 | Last captured direction, 1 = write |
| dir_valid_o | output | 1 | One-cycle strobe for a new direction |
| data_o | output | 8 | Last captured data byte |
| data_valid_o | output | 1 | One-cycle strobe for a new data byte |
| brk_o | output | 1 | One-cycle strobe for a break pulse |

## Verification
The embedded assertions check, on every cycle, the following properties:
- The counter never passes its saturation point.
- Pulse reports appear only after the line has returned high.
- The four strobes are mutually exclusive.
- A break always leaves the parser in ADDR at bit position zero.
- An invalid pulse leaves the parser untouched.
- Address and direction hold still between their strobes.

Other behaviour can only be shown by the bench's scenarios:
- Correct bit order.
- The exact window edges at 16/17, 50/51, 85/86, 145/146 and 190/191 cycles.
- Discarding of a partial frame after a break.
- Break detection on a very long low.

// File: rtl/pw_pkg.sv
package pw_pkg;
    typedef enum logic [1:0] {
        PK_ZERO  = 2'd0,
        PK_ONE   = 2'd1,
        PK_BREAK = 2'd2,
        PK_BAD   = 2'd3
    } pulse_e;

    typedef enum logic [1:0] {
        ST_ADDR = 2'd0,
        ST_DIR  = 2'd1,
        ST_DATA = 2'd2
    } fsm_e;

    function automatic longint unsigned us_to_ticks(input longint unsigned hz,
                                                    input longint unsigned us);
        return (hz * us) / 64'd1_000_000;
    endfunction
endpackage

// File: rtl/pw_sync.sv
module pw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-2:0], d_i};
        end
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/pw_timer.sv
module pw_timer
    import pw_pkg::*;
#(
    parameter longint unsigned CLK_HZ      = 50_000_000,
    parameter int unsigned     BRK_US      = 190,
    parameter int unsigned     ZERO_MIN_US = 86,
    parameter int unsigned     ZERO_MAX_US = 145,
    parameter int unsigned     ONE_MIN_US  = 17,
    parameter int unsigned     ONE_MAX_US  = 50
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   s_i,
    output logic   sym_vld_o,
    output pulse_e sym_o
);
    localparam longint unsigned BRK_T = us_to_ticks(CLK_HZ, 64'(BRK_US));
    localparam int CW = $clog2(BRK_T + 2);
    localparam logic [CW-1:0] T_BRK  = CW'(BRK_T);
    localparam logic [CW-1:0] T_Z_LO = CW'(us_to_ticks(CLK_HZ, 64'(ZERO_MIN_US)));
    localparam logic [CW-1:0] T_Z_HI = CW'(us_to_ticks(CLK_HZ, 64'(ZERO_MAX_US)));
    localparam logic [CW-1:0] T_O_LO = CW'(us_to_ticks(CLK_HZ, 64'(ONE_MIN_US)));
    localparam logic [CW-1:0] T_O_HI = CW'(us_to_ticks(CLK_HZ, 64'(ONE_MAX_US)));
    localparam logic [CW-1:0] CMAX   = T_BRK + CW'(1);

    logic          s_d;
    logic [CW-1:0] cnt;
    logic          fall, rise;
    pulse_e        kind;

    assign fall = s_d & ~s_i;
    assign rise = ~s_d & s_i;

    always_comb begin
        if (cnt > T_BRK)
            kind = PK_BREAK;
        else if (cnt >= T_Z_LO && cnt <= T_Z_HI)
            kind = PK_ZERO;
        else if (cnt >= T_O_LO && cnt <= T_O_HI)
            kind = PK_ONE;
        else
            kind = PK_BAD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_d       <= 1'b1;
            cnt       <= '0;
            sym_vld_o <= 1'b0;
            sym_o     <= PK_BAD;
        end else begin
            s_d       <= s_i;
            sym_vld_o <= rise;
            if (fall)
                cnt <= CW'(1);
            else if (!s_i && cnt != CMAX)
                cnt <= cnt + CW'(1);
            if (rise)
                sym_o <= kind;
        end
    end

    // R10: the counter stops at its saturation point
    a_r10_cnt_saturates: assert property (@(posedge clk) disable iff (rst)
        cnt <= CMAX);

    // R1: a pulse is only reported once the line has gone high again
    a_r1_report_after_rise: assert property (@(posedge clk) disable iff (rst)
        sym_vld_o |-> s_d);
endmodule

// File: rtl/pw_parser.sv
module pw_parser
    import pw_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sym_vld_i,
    input  pulse_e            sym_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              addr_valid_o,
    output logic              dir_o,
    output logic              dir_valid_o,
    output logic [DATA_W-1:0] data_o,
    output logic              data_valid_o,
    output logic              brk_o
);
    localparam int ACC_W = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;
    localparam int IW    = $clog2(ACC_W);
    localparam logic [IW-1:0] A_LAST = IW'(ADDR_W - 1);
    localparam logic [IW-1:0] D_LAST = IW'(DATA_W - 1);

    fsm_e             st, nxt;
    logic [IW-1:0]    idx;
    logic [ACC_W-1:0] acc, acc_w;
    logic             is_bit, is_brk, bval;

    assign is_brk = sym_vld_i && (sym_i == PK_BREAK);
    assign is_bit = sym_vld_i && (sym_i == PK_ZERO || sym_i == PK_ONE);
    assign bval   = (sym_i == PK_ONE);

    always_comb begin
        acc_w      = acc;
        acc_w[idx] = bval;
    end

    always_comb begin
        nxt = st;
        if (is_brk) begin
            nxt = ST_ADDR;
        end else if (is_bit) begin
            unique case (st)
                ST_ADDR: if (idx == A_LAST) nxt = ST_DIR;
                ST_DIR:  nxt = ST_DATA;
                ST_DATA: if (idx == D_LAST) nxt = ST_ADDR;
                default: nxt = ST_ADDR;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= ST_ADDR;
        else     st <= nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx          <= '0;
            acc          <= '0;
            addr_o       <= '0;
            dir_o        <= 1'b0;
            data_o       <= '0;
            addr_valid_o <= 1'b0;
            dir_valid_o  <= 1'b0;
            data_valid_o <= 1'b0;
            brk_o        <= 1'b0;
        end else begin
            addr_valid_o <= 1'b0;
            dir_valid_o  <= 1'b0;
            data_valid_o <= 1'b0;
            brk_o        <= is_brk;
            if (is_brk) begin
                idx <= '0;
            end else if (is_bit) begin
                unique case (st)
                    ST_ADDR: begin
                        acc <= acc_w;
                        if (idx == A_LAST) begin
                            addr_o       <= acc_w[ADDR_W-1:0];
                            addr_valid_o <= 1'b1;
                            idx          <= '0;
                        end else begin
                            idx <= idx + IW'(1);
                        end
                    end
                    ST_DIR: begin
                        dir_o       <= bval;
                        dir_valid_o <= 1'b1;
                        idx         <= '0;
                    end
                    ST_DATA: begin
                        acc <= acc_w;
                        if (idx == D_LAST) begin
                            data_o       <= acc_w[DATA_W-1:0];
                            data_valid_o <= 1'b1;
                            idx          <= '0;
                        end else begin
                            idx <= idx + IW'(1);
                        end
                    end
                    default: idx <= '0;
                endcase
            end
        end
    end

    // R2: a break leaves the parser at the start of an address
    a_r2_break_to_addr: assert property (@(posedge clk) disable iff (rst)
        is_brk |=> (st == ST_ADDR) && (idx == '0));

    // R5: an invalid pulse does not move the parser
    a_r5_bad_no_advance: assert property (@(posedge clk) disable iff (rst)
        (sym_vld_i && sym_i == PK_BAD) |=> (st == $past(st)) && (idx == $past(idx)));

    // R9: address and direction change only with their strobes
    a_r9_addr_hold: assert property (@(posedge clk) disable iff (rst)
        !addr_valid_o |-> $stable(addr_o));
    a_r9_dir_hold: assert property (@(posedge clk) disable iff (rst)
        !dir_valid_o |-> $stable(dir_o));

    // R7: a direction strobe only follows a completed address field
    a_r7_dir_after_addr: assert property (@(posedge clk) disable iff (rst)
        addr_valid_o |-> (st == ST_DIR));
endmodule

// File: rtl/pw_frame_mon.sv
module pw_frame_mon
    import pw_pkg::*;
#(
    parameter longint unsigned CLK_HZ = 50_000_000,
    parameter int              ADDR_W = 7,
    parameter int              DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              addr_valid_o,
    output logic              dir_o,
    output logic              dir_valid_o,
    output logic [DATA_W-1:0] data_o,
    output logic              data_valid_o,
    output logic              brk_o
);
    logic   line_s;
    logic   sym_vld;
    pulse_e sym;

    pw_sync #(.STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (line_i),
        .q_o (line_s)
    );

    pw_timer #(.CLK_HZ(CLK_HZ)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .s_i       (line_s),
        .sym_vld_o (sym_vld),
        .sym_o     (sym)
    );

    pw_parser #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_parser (
        .clk          (clk),
        .rst          (rst),
        .sym_vld_i    (sym_vld),
        .sym_i        (sym),
        .addr_o       (addr_o),
        .addr_valid_o (addr_valid_o),
        .dir_o        (dir_o),
        .dir_valid_o  (dir_valid_o),
        .data_o       (data_o),
        .data_valid_o (data_valid_o),
        .brk_o        (brk_o)
    );

    // R6: at most one strobe per cycle
    a_r6_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({addr_valid_o, dir_valid_o, data_valid_o, brk_o}));
endmodule

// File: tb/pw_frame_mon_bench.sv
module pw_frame_mon_bench;
    // 1 MHz threshold basis: one clock cycle per microsecond of line time
    localparam longint unsigned TB_HZ = 1_000_000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       line = 1'b1;
    logic [6:0] addr;
    logic       addr_valid, dir, dir_valid, data_valid, brk;
    logic [7:0] data;

    int n_chk = 0;
    int n_err = 0;
    int n_addr = 0, n_dir = 0, n_data = 0, n_brk = 0;
    logic [6:0] m_addr = '0;
    logic       m_dir = 1'b0;
    logic [7:0] m_data = '0;
    logic [6:0] addr_at_data = '0;
    logic       dir_at_data = 1'b0;

    always #2.5 clk = ~clk;

    pw_frame_mon #(.CLK_HZ(TB_HZ)) u_pw_frame_mon (
        .clk          (clk),
        .rst          (rst),
        .line_i       (line),
        .addr_o       (addr),
        .addr_valid_o (addr_valid),
        .dir_o        (dir),
        .dir_valid_o  (dir_valid),
        .data_o       (data),
        .data_valid_o (data_valid),
        .brk_o        (brk)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (addr_valid) begin n_addr++; m_addr = addr; end
            if (dir_valid)  begin n_dir++;  m_dir = dir; end
            if (data_valid) begin
                n_data++; m_data = data;
                addr_at_data = addr; dir_at_data = dir;
            end
            if (brk) n_brk++;
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse(input int len);
        @(negedge clk);
        line = 1'b0;
        repeat (len) @(negedge clk);
        line = 1'b1;
        repeat (20) @(negedge clk);
    endtask

    task automatic send_bit(input logic b, input int k);
        int w;
        if (b) w = (k % 3 == 0) ? 17 : (k % 3 == 1) ? 50 : 33;
        else   w = (k % 3 == 0) ? 86 : (k % 3 == 1) ? 145 : 110;
        pulse(w);
    endtask

    task automatic send_bits(input logic [15:0] v, input int from, input int upto, input int k0);
        for (int i = from; i < upto; i++) send_bit(v[i], k0 + i);
    endtask

    // layout: {data[15:8], dir[7], addr[6:0]}
    localparam logic [15:0] VEC [0:3] = '{16'hA5D3, 16'h0000, 16'hFFFF, 16'h3C2A};

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int a0, d0, b0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 addr", addr, 0);
        check("R11 data", data, 0);
        check("R11 dir", dir, 0);
        check("R11 strobes", {addr_valid, dir_valid, data_valid, brk}, 0);

        // Vector table: R3 R4 R6 R7 R8 R9 with boundary widths 17/50/86/145
        for (int v = 0; v < 4; v++) begin
            a0 = n_addr; d0 = n_data;
            send_bits(VEC[v], 0, 16, v);
            check("R6 addr", m_addr, VEC[v][6:0]);
            check("R7 dir", m_dir, VEC[v][7]);
            check("R8 data", m_data, VEC[v][15:8]);
            check("R8 one frame", (n_addr - a0) * 10 + (n_data - d0), 11);
            check("R9 addr held at data", addr_at_data, VEC[v][6:0]);
            check("R9 dir held at data", dir_at_data, VEC[v][7]);
        end

        // R5: out-of-window pulses mid-address do not advance the parser
        a0 = n_addr; b0 = n_brk;
        send_bits(16'h9B61, 0, 3, 0);
        pulse(16); pulse(51); pulse(85); pulse(146); pulse(190);
        check("R5 no break", n_brk - b0, 0);
        check("R5 no address yet", n_addr - a0, 0);
        send_bits(16'h9B61, 3, 16, 0);
        check("R5 addr intact", m_addr, 7'h61);
        check("R5 data intact", m_data, 8'h9B);

        // R2: break discards a partial frame (five address bits)
        a0 = n_addr; b0 = n_brk;
        send_bits(16'h7F7F, 0, 5, 1);
        pulse(191);
        check("R2 break strobe", n_brk - b0, 1);
        check("R2 no address", n_addr - a0, 0);
        send_bits(16'h4E15, 0, 16, 2);
        check("R2 addr after break", m_addr, 7'h15);
        check("R2 data after break", m_data, 8'h4E);

        // R2: break in the data field
        d0 = n_data;
        send_bits(16'hFFFF, 0, 12, 0);
        pulse(250);
        send_bits(16'h01C0, 0, 16, 1);
        check("R2 data frame restart", n_data - d0, 1);
        check("R2 data value", m_data, 8'h01);
        check("R7 write dir", m_dir, 1);

        // R10: a very long low saturates and still reports a break
        b0 = n_brk;
        pulse(3000);
        check("R10 long low is break", n_brk - b0, 1);
        send_bits(16'h8003, 0, 16, 0);
        check("R10 parser after long low", m_addr, 7'h03);

        // R1: a low still in progress yields no report until the rise
        b0 = n_brk;
        @(negedge clk); line = 1'b0;
        repeat (400) @(negedge clk);
        check("R1 no report while low", n_brk - b0, 0);
        line = 1'b1;
        repeat (10) @(negedge clk);
        check("R1 report on rise", n_brk - b0, 1);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule